// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns fetch, read and write requests from a controller core into external memory bus cycles. Time is cut into machine cycles of twelve clock periods, grouped into six states of two clocks each. Every external cycle fills one whole machine cycle. A latch-enable pulse marks the low address byte on a shared lane. Next comes either a short instruction-fetch strobe or a longer read or write strobe. A separate high address byte stays valid for the full twelve clocks.

The core presents a request with an operation code, a 16-bit address and write data. The sequencer samples the request only on the clock edge that closes a machine cycle. It pulses `req_taken_o` in the first clock of the cycle it starts, and keeps `busy_o` high through the last clock of that cycle. For fetch and read cycles, the byte on the lane is captured on the edge where the strobe returns high, and it is presented for one clock with `rsp_valid_o`. The lane is an output value plus an output enable, so the pad ring can build the tri-state driver. While no cycle runs, all strobes are inactive and nothing is driven.

Top module: `extbus_seq`

## Requirements
- R1: During and directly after reset, the latch enable is low, the three active-low strobes are high, the lane enable is low, the high address byte is zero, and `busy_o`, `req_taken_o` and `rsp_valid_o` are low.
- R2: The machine cycle is 12 clocks, numbered 0 to 11. A request is sampled only on the edge that ends clock 11. The cycle it starts has `req_taken_o` high in clock 0 only and `busy_o` high in clocks 0 to 11. A held request is therefore taken within 12 clocks, and every accepted request produces exactly one bus cycle, in issue order.
- R3: The operation code `req_op_i` is 01 for fetch, 10 for read and 11 for write. Code 00 with `req_valid_i` high is no request: no cycle starts and `busy_o` stays low.
- R4: The latch enable is high in clocks 0 and 1 of a bus cycle and low in clocks 2 to 11.
- R5: The lane is driven with address bits 7..0 in clocks 0 to 2, which is one clock past the latch-enable fall. The high port carries address bits 15..8 in all 12 clocks.
- R6: In a fetch cycle the fetch strobe is low in clocks 3, 4 and 5 only, and the read and write strobes stay high.
- R7: In a read cycle the read strobe is low in clocks 5 to 10, and in a write cycle the write strobe is low in clocks 5 to 10. The fetch strobe stays high in both, and at most one strobe is ever low.
- R8: In a write cycle the lane drives the write data in clocks 4 to 11. In clock 3 of every cycle, and in clocks 3 to 11 of fetch and read cycles, the lane enable is low.
- R9: A fetch captures the lane on the edge ending clock 5 and shows it with `rsp_valid_o` in clock 6. A read captures on the edge ending clock 10 and shows it in clock 11. `rsp_valid_o` is low at all other times, including write cycles.
- R10: A request held across a cycle boundary starts the next cycle with no idle clock between the two.
- R11: While no bus cycle runs, the latch enable is low, all strobes are high, the lane enable is low and the high byte is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, one period per oscillator tick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core has a request pending |
| req_op_i | input | 2 | 00 none, 01 fetch, 10 read, 11 write |
| req_addr_i | input | 16 | Request address |
| req_wdata_i | input | 8 | Write data |
| req_taken_o | output | 1 | First clock of the cycle serving the request |
| busy_o | output | 1 | A bus cycle is in progress |
| rsp_valid_o | output | 1 | Captured byte valid this clock |
| rsp_data_o | output | 8 | Captured instruction or data byte |
| bus_ale_o | output | 1 | Address latch enable, active high |
| bus_psen_n_o | output | 1 | Instruction fetch strobe, active low |
| bus_rd_n_o | output | 1 | Data read strobe, active low |
| bus_wr_n_o | output | 1 | Data write strobe, active low |
| bus_ad_o | output | 8 | Shared lane: low address, then write data |
| bus_ad_oe_o | output | 1 | Lane output enable |
| bus_ad_i | input | 8 | Lane value seen at the pad |
| bus_ahi_o | output | 8 | High address byte |

## Verification
The assertions assume that the core changes its request fields only after it sees `req_taken_o`, or while nothing is pending. They also assume that the pad returns a meaningful lane value only while a fetch or read strobe is low, and that the core never treats code 00 as an operation. The stimulus changes request inputs on falling clock edges, and releases or replaces a request only in the clock where `req_taken_o` is seen. An external memory model answers only while a strobe is low and drives a marker byte at all other times, so a capture one edge early or late shows up as a wrong response.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

    parameter int unsigned ADDR_W = 16;
    parameter int unsigned LANE_W = 8;
    localparam int unsigned HI_W  = ADDR_W - LANE_W;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_FETCH = 2'b01,
        OP_READ  = 2'b10,
        OP_WRITE = 2'b11
    } bus_op_e;

    // Registered pin image of the external bus
    typedef struct packed {
        logic              ale;
        logic              psen_n;
        logic              rd_n;
        logic              wr_n;
        logic              ad_oe;
        logic [LANE_W-1:0] ad;
        logic [HI_W-1:0]   ahi;
    } pins_t;

    localparam pins_t PINS_IDLE = '{
        ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
        ad_oe: 1'b0, ad: '0, ahi: '0
    };

    function automatic logic in_window(input int unsigned ph,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (ph >= lo) && (ph <= hi);
    endfunction

endpackage

// File: rtl/extbus_cycle_timer.sv
module extbus_cycle_timer #(
    parameter int unsigned CYCLE_CLKS = 12,
    parameter int unsigned PW         = $clog2(CYCLE_CLKS)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    output logic [PW-1:0] phase_q_o,
    output logic [PW-1:0] phase_d_o,
    output logic          wrap_o
);

    localparam logic [PW-1:0] LAST_PH = PW'(CYCLE_CLKS - 1);

    logic [PW-1:0] phase_d, phase_q;
    logic          wrap;

    always_comb begin
        wrap    = (phase_q == LAST_PH);
        phase_d = wrap ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase_q_o = phase_q;
    assign phase_d_o = phase_d;
    assign wrap_o    = wrap;

endmodule

// File: rtl/extbus_strobe_gen.sv
module extbus_strobe_gen
    import extbus_pkg::*;
#(
    parameter int unsigned PW         = 4,
    parameter int unsigned ALE_LEN    = 2,
    parameter int unsigned ADDR_LAST  = 2,
    parameter int unsigned PSEN_FIRST = 3,
    parameter int unsigned PSEN_LAST  = 5,
    parameter int unsigned STB_FIRST  = 5,
    parameter int unsigned STB_LAST   = 10,
    parameter int unsigned WD_FIRST   = 4,
    parameter int unsigned WD_LAST    = 11
) (
    input  bus_op_e           op_i,
    input  logic [PW-1:0]     phase_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANE_W-1:0] wdata_i,
    output pins_t             pins_o
);

    always_comb begin
        int unsigned ph;
        ph     = 32'(phase_i);
        pins_o = PINS_IDLE;
        if (op_i != OP_NONE) begin
            pins_o.ahi = addr_i[ADDR_W-1:LANE_W];
            pins_o.ale = in_window(ph, 0, ALE_LEN - 1);
            if (in_window(ph, 0, ADDR_LAST)) begin
                pins_o.ad_oe = 1'b1;
                pins_o.ad    = addr_i[LANE_W-1:0];
            end
            unique case (op_i)
                OP_FETCH: pins_o.psen_n = !in_window(ph, PSEN_FIRST, PSEN_LAST);
                OP_READ:  pins_o.rd_n   = !in_window(ph, STB_FIRST, STB_LAST);
                OP_WRITE: begin
                    pins_o.wr_n = !in_window(ph, STB_FIRST, STB_LAST);
                    if (in_window(ph, WD_FIRST, WD_LAST)) begin
                        pins_o.ad_oe = 1'b1;
                        pins_o.ad    = wdata_i;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/extbus_rsp_capture.sv
module extbus_rsp_capture
    import extbus_pkg::*;
#(
    parameter int unsigned PW        = 4,
    parameter int unsigned PSEN_LAST = 5,
    parameter int unsigned STB_LAST  = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  bus_op_e           op_i,
    input  logic [PW-1:0]     phase_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic              rsp_valid_o,
    output logic [LANE_W-1:0] rsp_data_o
);

    typedef struct packed {
        logic              valid;
        logic [LANE_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = 1'b0;
        // Sample on the edge where the active strobe goes back high
        if ((op_i == OP_FETCH && phase_i == PW'(PSEN_LAST)) ||
            (op_i == OP_READ  && phase_i == PW'(STB_LAST))) begin
            cap_d.valid = 1'b1;
            cap_d.data  = lane_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rsp_valid_o = cap_q.valid;
    assign rsp_data_o  = cap_q.data;

endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
    import extbus_pkg::*;
#(
    parameter int unsigned STATES         = 6,
    parameter int unsigned CLKS_PER_STATE = 2,
    parameter int unsigned ALE_LEN        = 2,
    parameter int unsigned ADDR_HOLD      = 1,
    parameter int unsigned PSEN_GAP       = 1,
    parameter int unsigned PSEN_LEN       = 3,
    parameter int unsigned STB_GAP        = 3,
    parameter int unsigned STB_LEN        = 6,
    parameter int unsigned WD_LEAD        = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [1:0]        req_op_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [LANE_W-1:0] req_wdata_i,
    output logic              req_taken_o,
    output logic              busy_o,
    output logic              rsp_valid_o,
    output logic [LANE_W-1:0] rsp_data_o,
    output logic              bus_ale_o,
    output logic              bus_psen_n_o,
    output logic              bus_rd_n_o,
    output logic              bus_wr_n_o,
    output logic [LANE_W-1:0] bus_ad_o,
    output logic              bus_ad_oe_o,
    input  logic [LANE_W-1:0] bus_ad_i,
    output logic [HI_W-1:0]   bus_ahi_o
);

    localparam int unsigned CYCLE_CLKS = STATES * CLKS_PER_STATE;
    localparam int unsigned PW         = $clog2(CYCLE_CLKS);
    localparam int unsigned ALE_FALL   = ALE_LEN;
    localparam int unsigned ADDR_LAST  = ALE_FALL + ADDR_HOLD - 1;
    localparam int unsigned PSEN_FIRST = ALE_FALL + PSEN_GAP;
    localparam int unsigned PSEN_LAST  = PSEN_FIRST + PSEN_LEN - 1;
    localparam int unsigned STB_FIRST  = ALE_FALL + STB_GAP;
    localparam int unsigned STB_LAST   = STB_FIRST + STB_LEN - 1;
    localparam int unsigned WD_FIRST   = STB_FIRST - WD_LEAD;
    localparam int unsigned WD_LAST    = CYCLE_CLKS - 1;

    typedef struct packed {
        bus_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [LANE_W-1:0] wdata;
        logic              taken;
        logic              busy;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    pins_t         pins_d, pins_q;
    logic [PW-1:0] phase_q, phase_d;
    logic          wrap;

    extbus_cycle_timer #(
        .CYCLE_CLKS (CYCLE_CLKS),
        .PW         (PW)
    ) timer_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .phase_q_o (phase_q),
        .phase_d_o (phase_d),
        .wrap_o    (wrap)
    );

    // Request acceptance happens only at the machine-cycle boundary
    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.taken = 1'b0;
        if (wrap) begin
            if (req_valid_i && bus_op_e'(req_op_i) != OP_NONE) begin
                ctl_d.op    = bus_op_e'(req_op_i);
                ctl_d.addr  = req_addr_i;
                ctl_d.wdata = req_wdata_i;
                ctl_d.taken = 1'b1;
            end else begin
                ctl_d.op = OP_NONE;
            end
        end
        ctl_d.busy = (ctl_d.op != OP_NONE);
    end

    extbus_strobe_gen #(
        .PW         (PW),
        .ALE_LEN    (ALE_LEN),
        .ADDR_LAST  (ADDR_LAST),
        .PSEN_FIRST (PSEN_FIRST),
        .PSEN_LAST  (PSEN_LAST),
        .STB_FIRST  (STB_FIRST),
        .STB_LAST   (STB_LAST),
        .WD_FIRST   (WD_FIRST),
        .WD_LAST    (WD_LAST)
    ) strobe_i (
        .op_i    (ctl_d.op),
        .phase_i (phase_d),
        .addr_i  (ctl_d.addr),
        .wdata_i (ctl_d.wdata),
        .pins_o  (pins_d)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q  <= '0;
            pins_q <= PINS_IDLE;
        end else begin
            ctl_q  <= ctl_d;
            pins_q <= pins_d;
        end
    end

    extbus_rsp_capture #(
        .PW        (PW),
        .PSEN_LAST (PSEN_LAST),
        .STB_LAST  (STB_LAST)
    ) capture_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .op_i        (ctl_q.op),
        .phase_i     (phase_q),
        .lane_i      (bus_ad_i),
        .rsp_valid_o (rsp_valid_o),
        .rsp_data_o  (rsp_data_o)
    );

    assign req_taken_o  = ctl_q.taken;
    assign busy_o       = ctl_q.busy;
    assign bus_ale_o    = pins_q.ale;
    assign bus_psen_n_o = pins_q.psen_n;
    assign bus_rd_n_o   = pins_q.rd_n;
    assign bus_wr_n_o   = pins_q.wr_n;
    assign bus_ad_o     = pins_q.ad;
    assign bus_ad_oe_o  = pins_q.ad_oe;
    assign bus_ahi_o    = pins_q.ahi;

endmodule

// File: rtl/extbus_seq_chk.sv
module extbus_seq_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       req_taken_o,
    input logic       busy_o,
    input logic       rsp_valid_o,
    input logic       bus_ale_o,
    input logic       bus_psen_n_o,
    input logic       bus_rd_n_o,
    input logic       bus_wr_n_o,
    input logic [7:0] bus_ad_o,
    input logic       bus_ad_oe_o,
    input logic [7:0] bus_ahi_o
);

    assert_taken_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_taken_o |-> busy_o);

    assert_ale_second_clock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bus_ale_o) |=> bus_ale_o);

    assert_ale_drops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_ale_o && $past(bus_ale_o)) |=> !bus_ale_o);

    assert_addr_before_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_ale_o |-> bus_ad_oe_o);

    assert_addr_after_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(bus_ale_o) |-> bus_ad_oe_o);

    assert_ahi_steady_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !req_taken_o) |-> $stable(bus_ahi_o));

    assert_psen_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(bus_psen_n_o) |=> !bus_psen_n_o);

    assert_one_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({~bus_psen_n_o, ~bus_rd_n_o, ~bus_wr_n_o}));

    assert_lane_released_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_psen_n_o || !bus_rd_n_o) |-> !bus_ad_oe_o);

    assert_wdata_lead_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(bus_wr_n_o) |-> ($past(bus_ad_oe_o) && $stable(bus_ad_o)));

    assert_rsp_after_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> ($past(!bus_psen_n_o || !bus_rd_n_o) && bus_psen_n_o && bus_rd_n_o));

    assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (!bus_ale_o && bus_psen_n_o && bus_rd_n_o && bus_wr_n_o && !bus_ad_oe_o));

endmodule

bind extbus_seq extbus_seq_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_taken_o  (req_taken_o),
    .busy_o       (busy_o),
    .rsp_valid_o  (rsp_valid_o),
    .bus_ale_o    (bus_ale_o),
    .bus_psen_n_o (bus_psen_n_o),
    .bus_rd_n_o   (bus_rd_n_o),
    .bus_wr_n_o   (bus_wr_n_o),
    .bus_ad_o     (bus_ad_o),
    .bus_ad_oe_o  (bus_ad_oe_o),
    .bus_ahi_o    (bus_ahi_o)
);

// File: tb/extbus_seq_tb_top.sv
module extbus_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [1:0]  op;
        logic [15:0] addr;
        logic [7:0]  wd;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_op;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_taken_o, busy_o, rsp_valid_o;
    logic [7:0]  rsp_data_o;
    logic        bus_ale_o, bus_psen_n_o, bus_rd_n_o, bus_wr_n_o, bus_ad_oe_o;
    logic [7:0]  bus_ad_o, bus_ad_i, bus_ahi_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    item_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    extbus_seq dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .req_valid_i  (req_valid),
        .req_op_i     (req_op),
        .req_addr_i   (req_addr),
        .req_wdata_i  (req_wdata),
        .req_taken_o  (req_taken_o),
        .busy_o       (busy_o),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_data_o   (rsp_data_o),
        .bus_ale_o    (bus_ale_o),
        .bus_psen_n_o (bus_psen_n_o),
        .bus_rd_n_o   (bus_rd_n_o),
        .bus_wr_n_o   (bus_wr_n_o),
        .bus_ad_o     (bus_ad_o),
        .bus_ad_oe_o  (bus_ad_oe_o),
        .bus_ad_i     (bus_ad_i),
        .bus_ahi_o    (bus_ahi_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [15:0] a, input bit is_fetch);
        return a[7:0] ^ a[15:8] ^ (is_fetch ? 8'h3C : 8'hC3);
    endfunction

    // External memory model: answers only while a strobe is low
    initial begin
        logic [15:0] lat;
        lat      = '0;
        bus_ad_i = 8'hEE;
        forever begin
            @(negedge clk);
            if (bus_ale_o) lat = {bus_ahi_o, bus_ad_o};
            if (!bus_psen_n_o)     bus_ad_i = mem_byte(lat, 1'b1);
            else if (!bus_rd_n_o)  bus_ad_i = mem_byte(lat, 1'b0);
            else                   bus_ad_i = 8'hEE;
        end
    end

    task automatic check_idle();
        chk(!busy_o,       "R11", "idle busy",  32'(busy_o), 0);
        chk(!bus_ale_o,    "R11", "idle ale",   32'(bus_ale_o), 0);
        chk(bus_psen_n_o && bus_rd_n_o && bus_wr_n_o, "R11", "idle strobes",
            {29'b0, bus_psen_n_o, bus_rd_n_o, bus_wr_n_o}, 7);
        chk(!bus_ad_oe_o,  "R11", "idle lane oe", 32'(bus_ad_oe_o), 0);
        chk(bus_ahi_o == 8'h00, "R11", "idle high byte", 32'(bus_ahi_o), 0);
        chk(!rsp_valid_o,  "R9",  "idle rsp_valid", 32'(rsp_valid_o), 0);
    endtask

    task automatic check_phase(input item_t it, input int k);
        bit   fe, rd, wr, oe_e, rv_e;
        logic [7:0] ad_e;
        fe   = (it.op == 2'b01);
        rd   = (it.op == 2'b10);
        wr   = (it.op == 2'b11);
        chk(busy_o, "R2", $sformatf("busy k=%0d", k), 32'(busy_o), 1);
        chk(req_taken_o == (k == 0), "R2", $sformatf("taken k=%0d", k), 32'(req_taken_o), 32'(k == 0));
        chk(bus_ale_o == (k <= 1), "R4", $sformatf("ale k=%0d", k), 32'(bus_ale_o), 32'(k <= 1));
        chk(bus_ahi_o == it.addr[15:8], "R5", $sformatf("high byte k=%0d", k),
            32'(bus_ahi_o), 32'(it.addr[15:8]));
        chk(bus_psen_n_o == !(fe && k >= 3 && k <= 5), fe ? "R6" : "R7",
            $sformatf("psen_n k=%0d", k), 32'(bus_psen_n_o), 32'(!(fe && k >= 3 && k <= 5)));
        chk(bus_rd_n_o == !(rd && k >= 5 && k <= 10), "R7", $sformatf("rd_n k=%0d", k),
            32'(bus_rd_n_o), 32'(!(rd && k >= 5 && k <= 10)));
        chk(bus_wr_n_o == !(wr && k >= 5 && k <= 10), "R7", $sformatf("wr_n k=%0d", k),
            32'(bus_wr_n_o), 32'(!(wr && k >= 5 && k <= 10)));
        oe_e = (k <= 2) || (wr && k >= 4);
        ad_e = (k <= 2) ? it.addr[7:0] : it.wd;
        chk(bus_ad_oe_o == oe_e, (k <= 2) ? "R5" : "R8", $sformatf("lane oe k=%0d", k),
            32'(bus_ad_oe_o), 32'(oe_e));
        if (oe_e)
            chk(bus_ad_o == ad_e, (k <= 2) ? "R5" : "R8", $sformatf("lane value k=%0d", k),
                32'(bus_ad_o), 32'(ad_e));
        rv_e = (fe && k == 6) || (rd && k == 11);
        chk(rsp_valid_o == rv_e, "R9", $sformatf("rsp_valid k=%0d", k), 32'(rsp_valid_o), 32'(rv_e));
        if (rv_e)
            chk(rsp_data_o == mem_byte(it.addr, fe), "R9", "captured byte",
                32'(rsp_data_o), 32'(mem_byte(it.addr, fe)));
    endtask

    // Monitor: pops the scoreboard at the start of each bus cycle
    initial begin
        item_t cur;
        int    k;
        bit    active;
        k      = 0;
        active = 0;
        cur    = '{op: 2'b00, addr: 16'h0, wd: 8'h0};
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (req_taken_o) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2", "cycle with no request", 1, 0);
                end else begin
                    cur = exp_q.pop_front();
                end
                k      = 0;
                active = 1;
            end
            if (active) begin
                check_phase(cur, k);
                k++;
                if (k == 12) active = 0;
            end else begin
                check_idle();
            end
        end
    end

    task automatic issue(input logic [1:0] op, input logic [15:0] addr, input logic [7:0] wd,
                         input string tag);
        int waited;
        waited = 0;
        exp_q.push_back('{op: op, addr: addr, wd: wd});
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr;
        req_wdata = wd;
        do begin
            @(negedge clk);
            waited++;
        end while (!req_taken_o && waited < 40);
        chk(waited <= 12, tag, "clocks until taken", 32'(waited), 12);
    endtask

    task automatic idle_for(input int n);
        req_valid = 1'b0;
        req_op    = 2'b00;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_op    = 2'b00;
        req_addr  = '0;
        req_wdata = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!bus_ale_o && bus_psen_n_o && bus_rd_n_o && bus_wr_n_o && !bus_ad_oe_o,
            "R1", "bus pins in reset",
            {27'b0, bus_ale_o, bus_psen_n_o, bus_rd_n_o, bus_wr_n_o, bus_ad_oe_o}, 32'h0E);
        chk(!busy_o && !req_taken_o && !rsp_valid_o && bus_ahi_o == 8'h00, "R1", "status in reset",
            {21'b0, busy_o, req_taken_o, rsp_valid_o, bus_ahi_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !bus_ale_o && bus_psen_n_o && !bus_ad_oe_o, "R1", "state after reset",
            {28'b0, busy_o, bus_ale_o, bus_psen_n_o, bus_ad_oe_o}, 32'h2);

        // Single cycles of each kind with gaps
        issue(2'b01, 16'h1234, 8'h00, "R2");
        idle_for(14);
        issue(2'b10, 16'hABCD, 8'h00, "R2");
        idle_for(14);
        issue(2'b11, 16'h00FF, 8'h5A, "R2");
        idle_for(20);

        // R3: code 00 held high must start nothing
        req_valid = 1'b1;
        req_op    = 2'b00;
        req_addr  = 16'h5555;
        repeat (30) @(negedge clk);
        chk(!busy_o, "R3", "busy after op 00", 32'(busy_o), 0);
        req_valid = 1'b0;

        // R10: back-to-back requests
        issue(2'b01, 16'h8001, 8'h00, "R10");
        issue(2'b10, 16'h7FFE, 8'h00, "R10");
        issue(2'b11, 16'hC33C, 8'hA5, "R10");
        issue(2'b10, 16'hFFFF, 8'h00, "R10");
        issue(2'b11, 16'h0000, 8'hFF, "R10");
        issue(2'b01, 16'h0F0F, 8'h00, "R10");
        idle_for(30);

        chk(exp_q.size() == 0, "R2", "all requests served", 32'(exp_q.size()), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule